// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block writes 8-bit registers inside a display panel through a three-wire serial link made of an active-low select, a serial clock and a data line. Each write is one 16-bit frame. The register address travels in the upper byte and the value in the lower byte, and the most significant bit goes out first. A host hands over single writes through a valid/ready command port. Two request inputs start built-in sequences: a five-write power-on list and a one-write power-off command.

The serial clock is made from the system clock. Each low phase and each high phase lasts a programmable number of system cycles. Data changes while the serial clock is low, so the panel samples it on the rising edge. Every frame opens with a quiet half-period: select is high and data is low. Select then falls, sixteen clock pulses follow, and select returns high. A one-cycle done pulse marks each completed frame.

Top module: `panel3w_writer`

## Requirements
- R1: A frame carries exactly 16 rising serial-clock edges while select is low. The bits sampled on those edges form {address[7:0], value[7:0]}, most significant bit first.
- R2: While idle, select and serial clock are both high. Before select falls, data is low and select stays high for one half-period. Select never falls while the clock is low, and the clock never goes low while select is high.
- R3: Inside a frame, data changes only in the cycle where the serial clock falls. It stays stable for the whole high phase, so the panel samples on the rising edge.
- R4: After the 16th high phase, select returns high with the clock high. `done` is high for exactly one cycle, and that cycle is the first cycle with select high again.
- R5: A power-on request sends five frames in this order: 0x051E, 0x055E, 0x078D, 0x1301, 0x055F.
- R6: A power-off request sends the single frame 0x055E.
- R7: The low phase and the high phase each last `halfPeriod` system cycles. A value of 0 acts as 1. The value is captured when a frame is loaded, so a change in the middle of a frame does not affect that frame.
- R8: `cmdReady` is high only when the writer is idle and no power request is present. It stays low for the whole of a frame or sequence.
- R9: When requests arrive in the same cycle, power-on wins over power-off, and power-off wins over a command. A command held valid is accepted after the winning sequence ends.
- R10: Power requests that arrive while a frame or sequence is in progress are ignored.
- R11: Between consecutive frames of a sequence, select stays high for one half-period.
- R12: After reset, select and clock are high, data is low, `done` is low and `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| halfPeriod | input | DIV_W | System cycles per serial-clock phase (0 treated as 1) |
| cmdValid | input | 1 | Command write request |
| cmdReady | output | 1 | Command accepted when high together with cmdValid |
| cmdAddr | input | 8 | Panel register address |
| cmdData | input | 8 | Panel register value |
| powerOnReq | input | 1 | Start the power-on write list |
| powerOffReq | input | 1 | Start the power-off write |
| done | output | 1 | One-cycle pulse at the end of every frame |
| serEnN | output | 1 | Active-low panel select |
| serClk | output | 1 | Serial clock, panel samples on rising edge |
| serData | output | 1 | Serial data |

## Verification
Two functions can fall in the same cycle: a command handshake and a power request, or both power requests together. The bench provokes this by raising `cmdValid` and `powerOffReq` at the same negative edge, and separately by pulsing both power requests together. The frames decoded from the pins must show the sequence first and the held command after it, or only the power-on list when the two requests collide. A pin monitor judges every frame's content, phase widths, select gaps and done alignment against the requirements.

// File: rtl/panel3w_pkg.sv
package panel3w_pkg;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int ON_LEN  = 5;
  localparam int IDX_W   = $clog2(ON_LEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LEAD,
    ST_BITLO,
    ST_BITHI
  } wrState_t;

  typedef enum logic [1:0] {
    SRC_CMD,
    SRC_ON,
    SRC_OFF
  } src_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic load;
    logic dropEn;
    logic fallClk;
    logic riseClk;
    logic raiseEn;
  } strobe_t;

  localparam logic [FRAME_W-1:0] OFF_WORD = 16'h055E;

  function automatic logic [FRAME_W-1:0] onWord(input logic [IDX_W-1:0] idx);
    logic [FRAME_W-1:0] w;
    case (idx)
      IDX_W'(0): w = 16'h051E;
      IDX_W'(1): w = 16'h055E;
      IDX_W'(2): w = 16'h078D;
      IDX_W'(3): w = 16'h1301;
      IDX_W'(4): w = 16'h055F;
      default:   w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/panel3w_ctrl.sv
module panel3w_ctrl
  import panel3w_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  phaseDone,
  input  logic                  cmdValid,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic [DATA_W-1:0]     cmdData,
  input  logic                  powerOnReq,
  input  logic                  powerOffReq,
  output logic                  cmdReady,
  output logic                  done,
  output strobe_t               stb,
  output logic [FRAME_W-1:0]    frameWord
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  wrState_t state;
  src_t src;
  logic [IDX_W-1:0] seqIdx;
  logic [BIT_W-1:0] bitCnt;

  logic isIdle, startOn, startOff, startCmd, lastFrame;

  always_comb begin
    isIdle    = (state == ST_IDLE);
    startOn   = isIdle && powerOnReq;
    startOff  = isIdle && !powerOnReq && powerOffReq;
    startCmd  = isIdle && !powerOnReq && !powerOffReq && cmdValid;
    lastFrame = (src != SRC_ON) || (seqIdx == IDX_W'(ON_LEN - 1));
  end

  assign cmdReady = isIdle && !powerOnReq && !powerOffReq;

  always_comb begin
    stb = '0;
    stb.run = !isIdle;
    frameWord = onWord(IDX_W'(seqIdx + 1'b1));
    case (state)
      ST_IDLE: begin
        stb.load = startOn || startOff || startCmd;
        if (startOn)       frameWord = onWord('0);
        else if (startOff) frameWord = OFF_WORD;
        else               frameWord = {cmdAddr, cmdData};
      end
      ST_SETUP: stb.dropEn  = phaseDone;
      ST_LEAD:  stb.fallClk = phaseDone;
      ST_BITLO: stb.riseClk = phaseDone;
      ST_BITHI: begin
        if (phaseDone) begin
          if (bitCnt == LAST_BIT) begin
            stb.raiseEn = 1'b1;
            stb.load    = !lastFrame;
          end else begin
            stb.fallClk = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      src    <= SRC_CMD;
      seqIdx <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= stb.raiseEn;
      case (state)
        ST_IDLE: begin
          if (stb.load) begin
            state  <= ST_SETUP;
            seqIdx <= '0;
            src    <= startOn ? SRC_ON : (startOff ? SRC_OFF : SRC_CMD);
          end
        end
        ST_SETUP: if (phaseDone) state <= ST_LEAD;
        ST_LEAD: begin
          if (phaseDone) begin
            state  <= ST_BITLO;
            bitCnt <= '0;
          end
        end
        ST_BITLO: if (phaseDone) state <= ST_BITHI;
        ST_BITHI: begin
          if (phaseDone) begin
            if (bitCnt == LAST_BIT) begin
              if (lastFrame) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_SETUP;
                seqIdx <= IDX_W'(seqIdx + 1'b1);
              end
            end else begin
              state  <= ST_BITLO;
              bitCnt <= BIT_W'(bitCnt + 1'b1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  seq_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqIdx < IDX_W'(ON_LEN));

  // R9
  on_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && powerOnReq) |=> (src == SRC_ON && state == ST_SETUP));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isIdle && state != ST_BITHI) |=> $stable(src));

endmodule

// File: rtl/panel3w_datapath.sv
module panel3w_datapath
  import panel3w_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIV_W-1:0]    halfPeriod,
  input  strobe_t             stb,
  input  logic [FRAME_W-1:0]  frameWord,
  output logic                phaseDone,
  output logic                serEnN,
  output logic                serClk,
  output logic                serData
);

  logic [DIV_W-1:0]   hLat;
  logic [DIV_W-1:0]   cnt;
  logic [FRAME_W-1:0] shiftReg;

  assign phaseDone = (cnt == DIV_W'(hLat - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hLat <= DIV_W'(1);
      cnt  <= '0;
    end else begin
      if (stb.load)
        hLat <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
      if (!stb.run || stb.load || phaseDone)
        cnt <= '0;
      else
        cnt <= DIV_W'(cnt + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serEnN   <= 1'b1;
      serClk   <= 1'b1;
      serData  <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (stb.dropEn) serEnN <= 1'b0;
      if (stb.riseClk) serClk <= 1'b1;
      if (stb.fallClk) begin
        serClk   <= 1'b0;
        serData  <= shiftReg[FRAME_W-1];
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
      if (stb.raiseEn) begin
        serEnN  <= 1'b1;
        serData <= 1'b0;
      end
      if (stb.load) begin
        shiftReg <= frameWord;
        serData  <= 1'b0;
      end
    end
  end

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serEnN) |-> (serClk && !serData));

  // R2
  clk_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |-> serClk);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!serEnN && serClk && $past(serClk)) |-> $stable(serData));

  // R7
  timer_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hLat != '0) && (cnt < hLat));

endmodule

// File: rtl/panel3w_writer.sv
module panel3w_writer
  import panel3w_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              powerOnReq,
  input  logic              powerOffReq,
  output logic              done,
  output logic              serEnN,
  output logic              serClk,
  output logic              serData
);

  strobe_t            stb;
  logic               phaseDone;
  logic [FRAME_W-1:0] frameWord;

  panel3w_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseDone  (phaseDone),
    .cmdValid   (cmdValid),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .powerOnReq (powerOnReq),
    .powerOffReq(powerOffReq),
    .cmdReady   (cmdReady),
    .done       (done),
    .stb        (stb),
    .frameWord  (frameWord)
  );

  panel3w_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .halfPeriod(halfPeriod),
    .stb       (stb),
    .frameWord (frameWord),
    .phaseDone (phaseDone),
    .serEnN    (serEnN),
    .serClk    (serClk),
    .serData   (serData)
  );

  // R4
  done_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (serEnN && serClk && $past(!serEnN)));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !serEnN |-> !cmdReady);

endmodule

// File: tb/sim_panel3w_writer.sv
`timescale 1ns/1ps
module sim_panel3w_writer;

  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] halfPeriod = DIV_W'(1);
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [7:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic powerOnReq = 1'b0;
  logic powerOffReq = 1'b0;
  logic done, serEnN, serClk, serData;

  always #2 clk = ~clk;

  panel3w_writer #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .halfPeriod(halfPeriod),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .powerOnReq(powerOnReq), .powerOffReq(powerOffReq),
    .done(done), .serEnN(serEnN), .serClk(serClk), .serData(serData)
  );

  // ---------------- pin monitor ----------------
  int frameCnt, doneCnt, minLo, maxLo, minHi, maxHi, minGap;
  int loRun, hiRun, gapRun, curBits;
  int startViol, dataViol, clkViol, rdyViol, doneViol;
  logic hadRise;
  logic [15:0] curWord;
  logic [15:0] frames [16];
  int bitsArr [16];
  logic clrReq = 1'b0, clrSeen = 1'b0;
  logic pEn = 1'b1, pClk = 1'b1, pData = 1'b0;

  always @(negedge clk) begin
    if (clrReq != clrSeen) begin
      clrSeen = clrReq;
      frameCnt = 0; doneCnt = 0; minLo = 9999; maxLo = 0; minHi = 9999; maxHi = 0;
      minGap = 9999; loRun = 0; hiRun = 0; gapRun = 0; curBits = 0; curWord = '0;
      startViol = 0; dataViol = 0; clkViol = 0; rdyViol = 0; doneViol = 0; hadRise = 1'b0;
    end else if (rstN) begin
      if (done !== (serEnN && !pEn)) doneViol++;
      if (done) doneCnt++;
      if (serEnN && !serClk) clkViol++;
      if (!serEnN && cmdReady) rdyViol++;
      if (!serEnN && serClk && pClk && serData !== pData) dataViol++;
      if (pEn && !serEnN) begin
        if (serData !== 1'b0 || serClk !== 1'b1) startViol++;
        if (hadRise && gapRun < minGap) minGap = gapRun;
        curBits = 0; curWord = '0;
      end
      if (serEnN) gapRun = pEn ? gapRun + 1 : 1;
      if (!serEnN && !pClk && serClk) begin
        curWord = {curWord[14:0], serData};
        curBits++;
        if (loRun < minLo) minLo = loRun;
        if (loRun > maxLo) maxLo = loRun;
      end
      if (!serEnN && pClk && !serClk && curBits > 0) begin
        if (hiRun < minHi) minHi = hiRun;
        if (hiRun > maxHi) maxHi = hiRun;
      end
      if (!pEn && serEnN) begin
        if (hiRun < minHi) minHi = hiRun;
        if (hiRun > maxHi) maxHi = hiRun;
        if (frameCnt < 16) begin
          frames[frameCnt] = curWord;
          bitsArr[frameCnt] = curBits;
        end
        frameCnt++;
        hadRise = 1'b1;
      end
      if (!serClk) loRun = pClk ? 1 : loRun + 1;
      if (serClk && !serEnN) hiRun = (pClk && !pEn) ? hiRun + 1 : 1;
    end
    pEn = serEnN; pClk = serClk; pData = serData;
  end

  // ---------------- check helpers ----------------
  int checks = 0, failures = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clearStats();
    clrReq = ~clrReq;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pushCmd(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a; cmdData = d;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (!cmdReady) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkFrame(input int idx, input logic [15:0] exp, input string req);
    check(frames[idx] == exp, req, int'(frames[idx]), int'(exp));
    check(bitsArr[idx] == 16, "R1 bits per frame", bitsArr[idx], 16);
  endtask

  task automatic checkClean(input string tag);
    check(startViol == 0, {"R2 quiet start ", tag}, startViol, 0);
    check(clkViol == 0, {"R2 clock idle high ", tag}, clkViol, 0);
    check(dataViol == 0, {"R3 data stable in high phase ", tag}, dataViol, 0);
    check(doneViol == 0, {"R4 done aligned ", tag}, doneViol, 0);
    check(rdyViol == 0, {"R8 ready low while busy ", tag}, rdyViol, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    check(serEnN == 1'b1, "R12 select idle", serEnN, 1);
    check(serClk == 1'b1, "R12 clock idle", serClk, 1);
    check(serData == 1'b0, "R12 data idle", serData, 0);
    check(done == 1'b0, "R12 done idle", done, 0);
    check(cmdReady == 1'b1, "R12 ready idle", cmdReady, 1);
  endtask

  task automatic testSingle();
    halfPeriod = DIV_W'(1);
    clearStats();
    pushCmd(8'h3C, 8'hA5);
    waitIdle();
    check(frameCnt == 1, "R1 frame count", frameCnt, 1);
    checkFrame(0, 16'h3CA5, "R1 single word");
    check(doneCnt == 1, "R4 done pulses", doneCnt, 1);
    check(minLo == 1 && maxLo == 1, "R7 low width h=1", maxLo, 1);
    checkClean("single");
  endtask

  task automatic testSlow();
    halfPeriod = DIV_W'(3);
    clearStats();
    pushCmd(8'h81, 8'h7E);
    waitIdle();
    checkFrame(0, 16'h817E, "R1 word h=3");
    check(minLo == 3 && maxLo == 3, "R7 low width h=3", maxLo, 3);
    check(minHi == 3 && maxHi == 3, "R7 high width h=3", maxHi, 3);
    checkClean("slow");
  endtask

  task automatic testZeroDiv();
    halfPeriod = '0;
    clearStats();
    pushCmd(8'hFF, 8'h00);
    waitIdle();
    checkFrame(0, 16'hFF00, "R1 word h=0");
    check(maxLo == 1 && maxHi == 1, "R7 zero acts as one", maxLo, 1);
  endtask

  task automatic testLatched();
    halfPeriod = DIV_W'(2);
    clearStats();
    pushCmd(8'h5A, 8'hC3);
    repeat (12) @(negedge clk);
    halfPeriod = DIV_W'(5);
    waitIdle();
    checkFrame(0, 16'h5AC3, "R7 latched word");
    check(minLo == 2 && maxLo == 2 && maxHi == 2, "R7 period captured at load", maxLo, 2);
  endtask

  task automatic testPowerOn();
    halfPeriod = DIV_W'(2);
    clearStats();
    @(negedge clk); powerOnReq = 1'b1;
    @(negedge clk); powerOnReq = 1'b0;
    check(cmdReady == 1'b0, "R8 ready low in sequence", cmdReady, 0);
    waitIdle();
    check(frameCnt == 5, "R5 power-on frame count", frameCnt, 5);
    checkFrame(0, 16'h051E, "R5 on step 0");
    checkFrame(1, 16'h055E, "R5 on step 1");
    checkFrame(2, 16'h078D, "R5 on step 2");
    checkFrame(3, 16'h1301, "R5 on step 3");
    checkFrame(4, 16'h055F, "R5 on step 4");
    check(doneCnt == 5, "R4 done per frame", doneCnt, 5);
    check(minGap == 2, "R11 select gap", minGap, 2);
    checkClean("power-on");
  endtask

  task automatic testPowerOff();
    halfPeriod = DIV_W'(1);
    clearStats();
    @(negedge clk); powerOffReq = 1'b1;
    @(negedge clk); powerOffReq = 1'b0;
    waitIdle();
    check(frameCnt == 1, "R6 power-off frame count", frameCnt, 1);
    checkFrame(0, 16'h055E, "R6 power-off word");
  endtask

  task automatic testCollision();
    halfPeriod = DIV_W'(1);
    clearStats();
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = 8'h42; cmdData = 8'h99; powerOffReq = 1'b1;
    @(negedge clk);
    powerOffReq = 1'b0;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    waitIdle();
    check(frameCnt == 2, "R9 frames after cmd/off collision", frameCnt, 2);
    checkFrame(0, 16'h055E, "R9 power-off first");
    checkFrame(1, 16'h4299, "R9 held command second");
    clearStats();
    @(negedge clk); powerOnReq = 1'b1; powerOffReq = 1'b1;
    @(negedge clk); powerOnReq = 1'b0; powerOffReq = 1'b0;
    waitIdle();
    check(frameCnt == 5, "R9 power-on beats power-off", frameCnt, 5);
    checkFrame(0, 16'h051E, "R9 on list first word");
  endtask

  task automatic testBusyIgnore();
    halfPeriod = DIV_W'(2);
    clearStats();
    pushCmd(8'h11, 8'h22);
    repeat (6) @(negedge clk);
    powerOffReq = 1'b1; powerOnReq = 1'b1;
    @(negedge clk);
    powerOffReq = 1'b0; powerOnReq = 1'b0;
    waitIdle();
    check(frameCnt == 1, "R10 busy requests ignored", frameCnt, 1);
    checkFrame(0, 16'h1122, "R10 frame unchanged");
  endtask

  initial begin
    logic timedOut;
    timedOut = 1'b0;
    clrReq = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    fork
      begin
        testReset();
        testSingle();
        testSlow();
        testZeroDiv();
        testLatched();
        testPowerOn();
        testPowerOff();
        testCollision();
        testBusyIgnore();
      end
      begin
        repeat (150000) @(negedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule